// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard controller for a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory access and writeback. Each cycle it takes the fields of the instruction in decode: its source registers, whether each source is really read, its destination, whether it writes, whether it is a load, and its branch kind. It keeps its own shadow of the destination and load information for the execute, memory and writeback stages. The shadow advances every cycle, and a stall drops a no-op into it. Operands are read only in decode and results are written only in writeback. Because of that fixed placement, only read-after-write hazards arise.

From the shadow and the decode fields the unit drives the operand selects for the execute stage, the select for the operand tested by a branch in decode, the PC and IF/ID write enables, a no-op insert for ID/EX, and the next-PC select. The register-zero test of a branch is computed outside the block on the forwarded operand. The unit only reads back its result. A branch decided in decode leaves one architectural delay slot. The instruction already fetched behind a branch is always kept, so nothing is ever flushed. A result that reaches writeback is assumed to be readable in decode in the same cycle, because the register file writes before it reads.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset, and whenever decode holds no valid instruction and the shadow stages are empty, all operand selects are 0, the PC and IF/ID enables are 1, the no-op insert is 0 and the next-PC select is 0.
- R2: An execute-stage operand (select encoding 00 register path, 01 memory-stage result, 10 writeback-stage result) selects 01 when the instruction one stage ahead writes the register it reads.
- R3: An execute-stage operand selects 10 when only the instruction two stages ahead writes the register it reads.
- R4: When both later stages write the register an operand reads, the memory-stage (younger) result wins and the select is 01.
- R5: Register 0 never causes forwarding or a stall, even when an instruction names it as its destination.
- R6: An instruction in decode that reads the destination of a load in execute causes exactly one stall cycle: PC and IF/ID enables 0, no-op insert 1. The reader then gets select 10 in execute.
- R7: A conditional branch (branch kind 01 = taken if zero, 10 = taken if non-zero) whose tested register is written by a non-load in execute stalls one cycle. The decode test select (1 = memory-stage result) is then 1.
- R8: A conditional branch whose tested register is the destination of a load in execute or memory stalls until the load reaches writeback: two cycles when the load is directly ahead.
- R9: With no stall, the next-PC select is 1 for kind 11 (unconditional), for kind 01 with the zero test true, and for kind 10 with the test false. IF/ID stays enabled so the delay-slot instruction is kept.
- R10: While a stall is asserted the next-PC select is 0, whatever the zero test says.
- R11: A decode slot marked invalid never stalls and never becomes a forwarding source later, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs | input | REG_AW | First source register (also the branch-tested register) |
| id_rt | input | REG_AW | Second source register |
| id_rs_used | input | 1 | First source is read in execute |
| id_rt_used | input | 1 | Second source is read in execute |
| id_dest | input | REG_AW | Destination register |
| id_wen | input | 1 | Instruction writes its destination |
| id_is_load | input | 1 | Instruction is a load |
| id_br_op | input | 2 | Branch kind: 00 none, 01 if zero, 10 if non-zero, 11 always |
| id_tst_zero | input | 1 | Forwarded tested register equals zero |
| ex_sel_a | output | 2 | Execute first operand select |
| ex_sel_b | output | 2 | Execute second operand select |
| id_sel_tst | output | 1 | Decode branch operand from memory-stage result |
| pc_wen | output | 1 | PC write enable |
| ifid_wen | output | 1 | IF/ID register write enable |
| idex_nop | output | 1 | Clear ID/EX control to a no-op |
| npc_sel | output | 1 | Next PC is the branch target |

## Verification
Several properties are checked on every cycle: an operand never takes the memory-stage path while that stage holds a load, register 0 or an unused operand never leaves the register path, every stall cycle leaves the execute shadow empty, and no more than two stalls happen in a row. Other behaviour depends on a sequence of instructions, and only the bench's scenarios can show it. This covers the exact number of stall cycles for a load before a reader or before a branch, the select a reader gets once the stall is over, the younger-wins priority, and the redirect taken or not taken with the delay slot kept. A reference model of the three shadow stages is compared against every output on every cycle of both the directed and the random streams.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source for an execute-stage operand
  typedef enum logic [1:0] {
    FW_RF    = 2'b00,
    FW_EXMEM = 2'b01,
    FW_MEMWB = 2'b10
  } fwd_sel_e;

  // Branch kind carried by the decode instruction
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQZ  = 2'b01,
    BR_NEZ  = 2'b10,
    BR_JMP  = 2'b11
  } br_op_e;

endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= 2'b00;
    else        sync_r <= {sync_r[0], 1'b1};
  end

  assign rst_q_n = sync_r[1];

endmodule

// File: rtl/hzd_track.sv
// Shadow of the later pipeline registers: execute, memory, writeback.
module hzd_track #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              d_wen,
  input  logic              d_load,
  input  logic              d_rs_used,
  input  logic              d_rt_used,
  input  logic [REG_AW-1:0] d_dest,
  input  logic [REG_AW-1:0] d_rs,
  input  logic [REG_AW-1:0] d_rt,
  output logic              x_wen,
  output logic              x_load,
  output logic              x_rs_used,
  output logic              x_rt_used,
  output logic [REG_AW-1:0] x_dest,
  output logic [REG_AW-1:0] x_rs,
  output logic [REG_AW-1:0] x_rt,
  output logic              m_wen,
  output logic              m_load,
  output logic [REG_AW-1:0] m_dest,
  output logic              w_wen,
  output logic [REG_AW-1:0] w_dest
);

  localparam int NSTG = 3;
  localparam int NLD  = 2;

  logic              wen_r  [NSTG];
  logic              wen_n  [NSTG];
  logic [REG_AW-1:0] dest_r [NSTG];
  logic [REG_AW-1:0] dest_n [NSTG];
  logic              load_r [NLD];
  logic              load_n [NLD];
  logic              rsu_r, rsu_n, rtu_r, rtu_n;
  logic [REG_AW-1:0] rs_r, rs_n, rt_r, rt_n;
  logic              adv;

  // the shadow moves every cycle; a stall enters as an empty slot
  assign adv = 1'b1;

  always_comb begin
    wen_n[0]  = issue & d_wen;
    dest_n[0] = issue ? d_dest : '0;
    load_n[0] = issue & d_load;
    rsu_n     = issue & d_rs_used;
    rtu_n     = issue & d_rt_used;
    rs_n      = issue ? d_rs : '0;
    rt_n      = issue ? d_rt : '0;
  end

  for (genvar k = 1; k < NSTG; k++) begin : g_shift
    always_comb begin
      wen_n[k]  = wen_r[k-1];
      dest_n[k] = dest_r[k-1];
    end
  end

  for (genvar k = 1; k < NLD; k++) begin : g_ldshift
    always_comb load_n[k] = load_r[k-1];
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wen_r[k]  <= 1'b0;
        dest_r[k] <= '0;
      end else if (adv) begin
        wen_r[k]  <= wen_n[k];
        dest_r[k] <= dest_n[k];
      end
    end
  end

  for (genvar k = 0; k < NLD; k++) begin : g_ld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   load_r[k] <= 1'b0;
      else if (adv) load_r[k] <= load_n[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsu_r <= 1'b0;
      rtu_r <= 1'b0;
      rs_r  <= '0;
      rt_r  <= '0;
    end else if (adv) begin
      rsu_r <= rsu_n;
      rtu_r <= rtu_n;
      rs_r  <= rs_n;
      rt_r  <= rt_n;
    end
  end

  assign x_wen     = wen_r[0];
  assign x_load    = load_r[0];
  assign x_rs_used = rsu_r;
  assign x_rt_used = rtu_r;
  assign x_dest    = dest_r[0];
  assign x_rs      = rs_r;
  assign x_rt      = rt_r;
  assign m_wen     = wen_r[1];
  assign m_load    = load_r[1];
  assign m_dest    = dest_r[1];
  assign w_wen     = wen_r[2];
  assign w_dest    = dest_r[2];

  // R6 R11: a slot not issued (stall or invalid) leaves execute empty
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!issue) |-> (!x_wen && !x_load && !x_rs_used && !x_rt_used));

endmodule

// File: rtl/hzd_fwd_cmp.sv
// One execute operand: pick the youngest later stage that writes it.
module hzd_fwd_cmp #(
  parameter int REG_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  src,
  input  logic               used,
  input  logic               m_wen,
  input  logic [REG_AW-1:0]  m_dest,
  input  logic               w_wen,
  input  logic [REG_AW-1:0]  w_dest,
  output hzd_pkg::fwd_sel_e  sel
);
  import hzd_pkg::*;

  logic live, hit_m, hit_w;

  always_comb begin
    live  = used && (src != '0);
    hit_m = live && m_wen && (m_dest == src);
    hit_w = live && w_wen && (w_dest == src);
    if (hit_m)      sel = FW_EXMEM;
    else if (hit_w) sel = FW_MEMWB;
    else            sel = FW_RF;
  end

  // R5
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == '0) || !used) |-> (sel == FW_RF));

endmodule

// File: rtl/hzd_ctl.sv
// Stall, decode-stage test select and redirect.
module hzd_ctl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_used,
  input  logic              id_rt_used,
  input  logic [1:0]        id_br_op,
  input  logic              id_tst_zero,
  input  logic              x_wen,
  input  logic              x_load,
  input  logic [REG_AW-1:0] x_dest,
  input  logic              m_wen,
  input  logic              m_load,
  input  logic [REG_AW-1:0] m_dest,
  output logic              stall,
  output logic              tst_fwd,
  output logic              redirect
);
  import hzd_pkg::*;

  localparam int RUN_W = 2;

  br_op_e           op;
  logic             x_live, m_live, is_cond;
  logic             load_use, br_on_x, br_on_mload, cond_met;
  logic [RUN_W-1:0] run_r, run_n;

  always_comb begin
    op      = br_op_e'(id_br_op);
    x_live  = x_wen && (x_dest != '0);
    m_live  = m_wen && (m_dest != '0);
    is_cond = id_valid && ((op == BR_EQZ) || (op == BR_NEZ));

    load_use = id_valid && x_live && x_load &&
               ((id_rs_used && (id_rs == x_dest)) ||
                (id_rt_used && (id_rt == x_dest)));
    br_on_x     = is_cond && x_live && (id_rs == x_dest);
    br_on_mload = is_cond && m_live && m_load && (id_rs == m_dest);
    stall       = load_use || br_on_x || br_on_mload;

    tst_fwd = is_cond && m_live && !m_load && (id_rs == m_dest);

    case (op)
      BR_EQZ:  cond_met = id_tst_zero;
      BR_NEZ:  cond_met = !id_tst_zero;
      BR_JMP:  cond_met = 1'b1;
      default: cond_met = 1'b0;
    endcase
    redirect = id_valid && !stall && cond_met;
  end

  // consecutive stall counter, saturating
  always_comb begin
    if (!stall)                    run_n = '0;
    else if (run_r != {RUN_W{1'b1}}) run_n = run_r + 1'b1;
    else                           run_n = run_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_r <= '0;
    else        run_r <= run_n;
  end

  // R8
  stall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && (run_r == 2'd2)));

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rs_used,
  input  logic              id_rt_used,
  input  logic [REG_AW-1:0] id_dest,
  input  logic              id_wen,
  input  logic              id_is_load,
  input  logic [1:0]        id_br_op,
  input  logic              id_tst_zero,
  output logic [1:0]        ex_sel_a,
  output logic [1:0]        ex_sel_b,
  output logic              id_sel_tst,
  output logic              pc_wen,
  output logic              ifid_wen,
  output logic              idex_nop,
  output logic              npc_sel
);
  import hzd_pkg::*;

  localparam int NSRC = 2;

  logic              rst_q_n;
  logic              stall, issue;
  logic              x_wen, x_load, x_rs_used, x_rt_used, m_wen, m_load, w_wen;
  logic [REG_AW-1:0] x_dest, x_rs, x_rt, m_dest, w_dest;
  logic [REG_AW-1:0] src_reg [NSRC];
  logic              src_use [NSRC];
  fwd_sel_e          src_sel [NSRC];

  hzd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign issue = id_valid && !stall;

  hzd_track #(.REG_AW(REG_AW)) u_track (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .issue     (issue),
    .d_wen     (id_wen),
    .d_load    (id_is_load),
    .d_rs_used (id_rs_used),
    .d_rt_used (id_rt_used),
    .d_dest    (id_dest),
    .d_rs      (id_rs),
    .d_rt      (id_rt),
    .x_wen     (x_wen),
    .x_load    (x_load),
    .x_rs_used (x_rs_used),
    .x_rt_used (x_rt_used),
    .x_dest    (x_dest),
    .x_rs      (x_rs),
    .x_rt      (x_rt),
    .m_wen     (m_wen),
    .m_load    (m_load),
    .m_dest    (m_dest),
    .w_wen     (w_wen),
    .w_dest    (w_dest)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_reg[g] = (g == 0) ? x_rs : x_rt;
    assign src_use[g] = (g == 0) ? x_rs_used : x_rt_used;

    hzd_fwd_cmp #(.REG_AW(REG_AW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .src    (src_reg[g]),
      .used   (src_use[g]),
      .m_wen  (m_wen),
      .m_dest (m_dest),
      .w_wen  (w_wen),
      .w_dest (w_dest),
      .sel    (src_sel[g])
    );
  end

  hzd_ctl #(.REG_AW(REG_AW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .id_valid    (id_valid),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_rs_used  (id_rs_used),
    .id_rt_used  (id_rt_used),
    .id_br_op    (id_br_op),
    .id_tst_zero (id_tst_zero),
    .x_wen       (x_wen),
    .x_load      (x_load),
    .x_dest      (x_dest),
    .m_wen       (m_wen),
    .m_load      (m_load),
    .m_dest      (m_dest),
    .stall       (stall),
    .tst_fwd     (id_sel_tst),
    .redirect    (npc_sel)
  );

  assign ex_sel_a = src_sel[0];
  assign ex_sel_b = src_sel[1];
  assign pc_wen   = !stall;
  assign ifid_wen = !stall;
  assign idex_nop = stall;

  // R2: a load's data is never taken from the memory-stage path
  no_load_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_sel_a == 2'b01) |-> !m_load);

  // R2
  no_load_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ex_sel_b == 2'b01) |-> !m_load);

  // R7: decode test never forwarded from an unfinished load
  no_load_tst_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    id_sel_tst |-> !m_load);

endmodule

// File: tb/sim_pipe_hazard_unit.sv
`timescale 1ns/100ps
module sim_pipe_hazard_unit;

  localparam int AW = 5;

  typedef struct packed {
    logic          valid;
    logic          wen;
    logic          load;
    logic          rs_used;
    logic          rt_used;
    logic [1:0]    br;
    logic [AW-1:0] dest;
    logic [AW-1:0] rs;
    logic [AW-1:0] rt;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          id_valid, id_rs_used, id_rt_used, id_wen, id_is_load, id_tst_zero;
  logic [AW-1:0] id_rs, id_rt, id_dest;
  logic [1:0]    id_br_op;
  logic [1:0]    ex_sel_a, ex_sel_b;
  logic          id_sel_tst, pc_wen, ifid_wen, idex_nop, npc_sel;

  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;
  ent_t pipe[$];
  logic [1:0] got_a, got_b;
  logic got_tst, got_ps, got_ifid;

  always #2.5 clk = ~clk;

  pipe_hazard_unit #(.REG_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
    .id_rs_used(id_rs_used), .id_rt_used(id_rt_used), .id_dest(id_dest),
    .id_wen(id_wen), .id_is_load(id_is_load), .id_br_op(id_br_op),
    .id_tst_zero(id_tst_zero), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .id_sel_tst(id_sel_tst), .pc_wen(pc_wen), .ifid_wen(ifid_wen),
    .idex_nop(idex_nop), .npc_sel(npc_sel)
  );

  function automatic ent_t nop_e();
    return '0;
  endfunction

  function automatic ent_t alu(int d, int s, int t);
    ent_t e = '0;
    e.valid = 1; e.wen = 1; e.rs_used = 1; e.rt_used = 1;
    e.dest = AW'(d); e.rs = AW'(s); e.rt = AW'(t);
    return e;
  endfunction

  function automatic ent_t ld(int d, int s);
    ent_t e = '0;
    e.valid = 1; e.wen = 1; e.load = 1; e.rs_used = 1;
    e.dest = AW'(d); e.rs = AW'(s);
    return e;
  endfunction

  function automatic ent_t sto(int s, int t);
    ent_t e = '0;
    e.valid = 1; e.rs_used = 1; e.rt_used = 1;
    e.rs = AW'(s); e.rt = AW'(t);
    return e;
  endfunction

  function automatic ent_t bra(int op, int s);
    ent_t e = '0;
    e.valid = 1; e.br = 2'(op); e.rs = AW'(s);
    return e;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [1:0] src_path(logic used, logic [AW-1:0] r);
    if (!used || r == 0) return 2'b00;
    for (int k = 1; k <= 2; k++)
      if (pipe[k].valid && pipe[k].wen && pipe[k].dest == r)
        return (k == 1) ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  // one clock: drive decode, compare all outputs with the model, advance model
  task automatic cyc(input ent_t d, input logic z, input string tag, output logic st);
    logic [1:0] ea, eb;
    logic etst, ep, cond;
    ent_t ex, mm;
    @(posedge clk); #1;
    id_valid = d.valid; id_rs = d.rs; id_rt = d.rt; id_rs_used = d.rs_used;
    id_rt_used = d.rt_used; id_dest = d.dest; id_wen = d.wen;
    id_is_load = d.load; id_br_op = d.br; id_tst_zero = z;
    @(negedge clk);
    ex = pipe[0]; mm = pipe[1];
    ea = src_path(ex.valid && ex.rs_used, ex.rs);
    eb = src_path(ex.valid && ex.rt_used, ex.rt);
    st = 0;
    if (d.valid && ex.valid && ex.wen && ex.load && ex.dest != 0 &&
        ((d.rs_used && d.rs == ex.dest) || (d.rt_used && d.rt == ex.dest))) st = 1;
    cond = d.valid && (d.br == 2'b01 || d.br == 2'b10);
    etst = 0;
    if (cond && d.rs != 0) begin
      if (ex.valid && ex.wen && ex.dest == d.rs) st = 1;
      if (mm.valid && mm.wen && mm.dest == d.rs) begin
        if (mm.load) st = 1; else etst = 1;
      end
    end
    ep = d.valid && !st && (d.br == 2'b11 || (d.br == 2'b01 && z) || (d.br == 2'b10 && !z));
    got_a = ex_sel_a; got_b = ex_sel_b; got_tst = id_sel_tst;
    got_ps = npc_sel; got_ifid = ifid_wen;
    chk(tag, "ex_sel_a", ex_sel_a, ea);
    chk(tag, "ex_sel_b", ex_sel_b, eb);
    chk(tag, "id_sel_tst", id_sel_tst, etst);
    chk(tag, "pc_wen", pc_wen, !st);
    chk(tag, "ifid_wen", ifid_wen, !st);
    chk(tag, "idex_nop", idex_nop, st);
    chk(tag, "npc_sel", npc_sel, ep);
    pipe.push_front((st || !d.valid) ? nop_e() : d);
    void'(pipe.pop_back());
  endtask

  task automatic issue(input ent_t d, input logic z, input string tag, output int stalls);
    logic st;
    stalls = 0;
    do begin
      cyc(d, z, tag, st);
      if (st) stalls++;
    end while (st && stalls < 8);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    int s;
    logic st;
    ent_t e;
    rst_n = 0;
    id_valid = 0; id_rs = 0; id_rt = 0; id_rs_used = 0; id_rt_used = 0;
    id_dest = 0; id_wen = 0; id_is_load = 0; id_br_op = 0; id_tst_zero = 0;
    repeat (3) pipe.push_back(nop_e());

    // R1: reset state, during and after release
    repeat (2) cyc(nop_e(), 0, "R1", st);
    rst_n = 1;
    repeat (4) cyc(nop_e(), 0, "R1", st);
    chk("R1", "pc_wen idle", pc_wen, 1);

    // R2: neighbour result forwarded from memory stage
    issue(alu(1, 2, 3), 0, "R2", s);
    issue(alu(4, 1, 3), 0, "R2", s);
    cyc(nop_e(), 0, "R2", st);
    chk("R2", "sel_a neighbour", got_a, 1);
    chk("R2", "sel_b untouched", got_b, 0);

    // R3: result two ahead from writeback
    issue(alu(5, 2, 2), 0, "R3", s);
    issue(alu(6, 2, 2), 0, "R3", s);
    issue(sto(2, 5), 0, "R3", s);
    cyc(nop_e(), 0, "R3", st);
    chk("R3", "sel_b two ahead", got_b, 2);

    // R4: both stages write the same register, younger wins
    issue(alu(7, 1, 1), 0, "R4", s);
    issue(alu(7, 2, 2), 0, "R4", s);
    issue(alu(8, 7, 7), 0, "R4", s);
    cyc(nop_e(), 0, "R4", st);
    chk("R4", "sel_a priority", got_a, 1);
    chk("R4", "sel_b priority", got_b, 1);

    // R5: register 0 never forwarded nor stalled
    issue(alu(0, 1, 1), 0, "R5", s);
    issue(alu(9, 0, 0), 0, "R5", s);
    cyc(nop_e(), 0, "R5", st);
    chk("R5", "sel_a r0", got_a, 0);
    issue(ld(0, 1), 0, "R5", s);
    issue(alu(9, 0, 0), 0, "R5", s);
    chk("R5", "stalls on r0 load", s, 0);

    // R6: load then immediate use
    issue(ld(10, 1), 0, "R6", s);
    issue(alu(11, 10, 2), 0, "R6", s);
    chk("R6", "load-use stalls", s, 1);
    cyc(nop_e(), 0, "R6", st);
    chk("R6", "sel_a after stall", got_a, 2);

    // R7 / R10: ALU result tested by a branch; zero=1 during stall must not redirect
    issue(alu(12, 1, 1), 0, "R10", s);
    issue(bra(1, 12), 1, "R10", s);
    chk("R7", "branch stalls", s, 1);
    chk("R7", "decode test forwarded", got_tst, 1);
    chk("R9", "beqz taken", got_ps, 1);
    chk("R9", "delay slot kept", got_ifid, 1);

    // R8: load then branch on its result
    issue(ld(13, 1), 0, "R8", s);
    issue(bra(2, 13), 0, "R8", s);
    chk("R8", "branch after load stalls", s, 2);
    chk("R8", "no decode forward", got_tst, 0);
    chk("R9", "bnez taken", got_ps, 1);

    // R9: branch outcomes
    issue(bra(1, 3), 0, "R9", s);
    chk("R9", "beqz not taken", got_ps, 0);
    issue(alu(20, 1, 1), 0, "R9", s);
    issue(bra(3, 0), 0, "R9", s);
    chk("R9", "jump taken", got_ps, 1);
    chk("R9", "jump keeps slot", got_ifid, 1);
    issue(bra(2, 4), 1, "R9", s);
    chk("R9", "bnez not taken", got_ps, 0);

    // R11: invalid decode slot
    issue(ld(14, 1), 0, "R11", s);
    e = alu(15, 14, 14); e.valid = 0;
    cyc(e, 0, "R11", st);
    chk("R11", "invalid slot stall", st, 0);
    issue(alu(16, 15, 15), 0, "R11", s);
    cyc(nop_e(), 0, "R11", st);
    chk("R11", "invalid slot not a source", got_a, 0);

    // random mixed stream on few registers (R4 priority and all paths)
    for (int i = 0; i < 600; i++) begin
      int kind = $urandom_range(0, 5);
      int a = $urandom_range(0, 3);
      int b = $urandom_range(0, 3);
      int c = $urandom_range(0, 3);
      case (kind)
        0: e = alu(a, b, c);
        1: e = ld(a, b);
        2: e = sto(b, c);
        3: e = bra($urandom_range(1, 3), b);
        4: begin e = alu(a, b, c); e.valid = 0; end
        default: e = nop_e();
      endcase
      issue(e, 1'($urandom_range(0, 1)), "R4", s);
    end

    repeat (3) cyc(nop_e(), 0, "R1", st);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule